// File: doc/BRIEF.md
# Bidirectional Strobed Port with Acknowledge-Gated Drivers

This block runs one 8-bit peripheral port in both directions over a single pin set. A falling edge on the peripheral's strobe line captures the byte on the shared pins into an input latch and raises an input-full flag. A host write fills a separate output latch and pulls the active-low output-full flag low. The output latch reaches the pins only while the peripheral holds its active-low acknowledge line low. At every other time the pin drivers stay disabled, so the shared bus is free for the peripheral to drive. The pad drivers are modelled as an output value plus an output-enable.

Five lines of an 8-bit control port carry the handshake, at fixed positions: bit 7 output-full (out, active low), bit 6 acknowledge (in, active low), bit 5 input-full (out), bit 4 strobe (in, active low) and bit 3 interrupt request (out). Bits 2..0 stay general-purpose lines. Their direction comes from the main controller, which also decodes the host bus and the control words. A single-bit set/reset command writes the two interrupt enables and the general-purpose output latch. A status byte shows the handshake state and the general-purpose lines.

There are two state machines.

- The input machine has the states IN_EMPTY and IN_FULL:
  - a strobe fall moves it from IN_EMPTY to IN_FULL;
  - a host read moves it from IN_FULL to IN_EMPTY;
  - a strobe fall while in IN_FULL reloads the latch and stays in IN_FULL.
- The output machine has the states OUT_IDLE, OUT_FULL, OUT_DRIVE and OUT_DONE:
  - a host write from any state goes to OUT_FULL;
  - an acknowledge fall in OUT_FULL goes to OUT_DRIVE;
  - an acknowledge rise in OUT_DRIVE goes to OUT_DONE;
  - OUT_DONE holds until the next write.

Top module: `bhp_port`

## Requirements
- R1: Reset has these effects:
  - output-full (`pc_o[7]`) is high;
  - input-full (`pc_o[5]`) and the interrupt request (`pc_o[3]`) are low;
  - `pa_oe` is low;
  - both interrupt enables and the general-purpose latch are cleared.
- R2: A strobe fall on `pc_i[4]` captures `pa_i` into the input latch (shown on `rdata`) and sets input-full one clock later.
- R3: A strobe fall while input-full is set overwrites the latch and input-full stays set.
- R4: A host read (`rd_a`) clears input-full one clock later, unless a strobe fall arrives in the same cycle. In that case the new byte is latched and input-full stays set.
- R5: A host write (`wr_a`) loads `wdata` into the output latch and drives output-full low one clock later.
- R6: `pa_oe` is high in exactly the cycles where acknowledge (`pc_i[6]`) is low, with no delay, and `pa_o` then carries the output latch.
- R7: An acknowledge fall while output-full is low returns output-full high one clock later.
- R8: The interrupt request is the OR of two terms:
  - input-full AND the input enable;
  - AND of the output enable with the "acknowledged" state. That state is entered one clock after acknowledge is released following an output transfer, and it ends at the next write.
- R9: A set/reset command (`bsr_we`, `bsr_sel`, `bsr_set`) writes the output enable when `bsr_sel` is 6 and the input enable when `bsr_sel` is 4. When `bsr_sel` is 0..2 it writes general-purpose latch bit `bsr_sel`. In each case the effect shows one clock later.
- R10: A set/reset command with `bsr_sel` equal to 3, 5 or 7 changes nothing.
- R11: The pin enables are fixed as follows:
  - `pc_oe` bits 7, 5 and 3 are 1;
  - `pc_oe` bits 6 and 4 are 0;
  - `pc_oe` bits 2..0 follow `gp_dir`;
  - `pc_o[2:0]` is the general-purpose latch.
- R12: The `stat` byte is {output-full, output enable, input-full, input enable, interrupt request, gp[2:0]}. For each gp bit, it shows the latch bit when `gp_dir` is 1 and the pin `pc_i` when `gp_dir` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_a | input | 1 | Host write strobe for the output latch |
| rd_a | input | 1 | Host read strobe for the input latch |
| wdata | input | DW | Host write data |
| rdata | output | DW | Input latch contents |
| bsr_we | input | 1 | Single-bit set/reset command valid |
| bsr_sel | input | 3 | Control-port bit selected by the command |
| bsr_set | input | 1 | Value written by the command |
| gp_dir | input | 3 | Direction of general-purpose lines, 1 = output |
| pa_i | input | DW | Shared data pins, sampled value |
| pa_o | output | DW | Shared data pins, driven value |
| pa_oe | output | 1 | Shared data pin driver enable |
| pc_i | input | 8 | Control-port pins, sampled value |
| pc_o | output | 8 | Control-port pins, driven value |
| pc_oe | output | 8 | Control-port pin driver enables |
| stat | output | 8 | Status byte |

## Verification
The bench targets the following cases:

- **Strobe and read in the same cycle.** A design that lets the read win loses the new byte and shows an empty port.
- **Strobe while full.** A design that drops a second strobe leaves a stale `rdata`.
- **Acknowledge gating.** `pa_oe` is checked in the acknowledge cycle itself, against both a registered enable and a write-driven enable.
- **Output interrupt.** The output term is checked before the acknowledge, after its release, and after the next write. A design that raises it on the acknowledge fall, or keeps it past a new write, fails.
- **Set/reset commands.** Commands aimed at the handshake bit positions must leave every output unchanged. This catches a decoder that maps them onto an enable or a general-purpose bit.

// File: rtl/bhp_pkg.sv
package bhp_pkg;
    typedef enum logic [0:0] {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_state_t;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_FULL  = 2'd1,
        OUT_DRIVE = 2'd2,
        OUT_DONE  = 2'd3
    } out_state_t;

    localparam int PC_W     = 8;
    localparam int GP_W     = 3;
    localparam int PIN_OBF  = 7;
    localparam int PIN_ACK  = 6;
    localparam int PIN_IBF  = 5;
    localparam int PIN_STB  = 4;
    localparam int PIN_INTR = 3;
endpackage

// File: rtl/bhp_in_ctl.sv
module bhp_in_ctl
    import bhp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stb_n,
    input  logic          rd_a,
    input  logic [DW-1:0] pa_i,
    output logic          ibf,
    output logic [DW-1:0] in_data
);
    in_state_t state, state_nx;
    logic      stb_q;
    logic      stb_fall;

    assign stb_fall = stb_q & ~stb_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= IN_EMPTY;
            stb_q <= 1'b1;
        end else begin
            state <= state_nx;
            stb_q <= stb_n;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            IN_EMPTY: if (stb_fall) state_nx = IN_FULL;
            IN_FULL:  if (!stb_fall && rd_a) state_nx = IN_EMPTY;
            default:  state_nx = IN_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) in_data <= '0;
        else if (stb_fall) in_data <= pa_i;
    end

    always_comb begin
        ibf = (state == IN_FULL);
    end

    AST_STROBE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        stb_fall |=> (ibf && in_data == $past(pa_i)));   // R2
    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (rd_a && !stb_fall && ibf) |=> !ibf);             // R4
endmodule

// File: rtl/bhp_out_ctl.sv
module bhp_out_ctl
    import bhp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ack_n,
    input  logic          wr_a,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] out_data,
    output logic          obf_n,
    output logic          out_done
);
    out_state_t state, state_nx;
    logic       ack_q;
    logic       ack_fall;
    logic       ack_rise;

    assign ack_fall = ack_q & ~ack_n;
    assign ack_rise = ~ack_q & ack_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OUT_IDLE;
            ack_q <= 1'b1;
        end else begin
            state <= state_nx;
            ack_q <= ack_n;
        end
    end

    always_comb begin
        state_nx = state;
        if (wr_a) begin
            state_nx = OUT_FULL;
        end else begin
            unique case (state)
                OUT_IDLE:  state_nx = OUT_IDLE;
                OUT_FULL:  if (ack_fall) state_nx = OUT_DRIVE;
                OUT_DRIVE: if (ack_rise) state_nx = OUT_DONE;
                OUT_DONE:  state_nx = OUT_DONE;
                default:   state_nx = OUT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_data <= '0;
        else if (wr_a) out_data <= wdata;
    end

    always_comb begin
        obf_n    = (state != OUT_FULL);
        out_done = (state == OUT_DONE);
    end

    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_a |=> (!obf_n && out_data == $past(wdata)));   // R5
    AST_ACK_RELEASES_OBF: assert property (@(posedge clk) disable iff (rst)
        (ack_fall && !wr_a && !obf_n) |=> obf_n);          // R7
    AST_DONE_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_done) |-> $past(ack_n) && !$past(wr_a)); // R8
endmodule

// File: rtl/bhp_ctl_bits.sv
module bhp_ctl_bits
    import bhp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            bsr_we,
    input  logic [2:0]      bsr_sel,
    input  logic            bsr_set,
    output logic            inte_in,
    output logic            inte_out,
    output logic [GP_W-1:0] gp_latch
);
    always_ff @(posedge clk) begin
        if (rst) begin
            inte_in  <= 1'b0;
            inte_out <= 1'b0;
        end else if (bsr_we) begin
            if (bsr_sel == 3'(PIN_ACK)) inte_out <= bsr_set;
            if (bsr_sel == 3'(PIN_STB)) inte_in  <= bsr_set;
        end
    end

    for (genvar g = 0; g < GP_W; g++) begin : g_gp
        always_ff @(posedge clk) begin
            if (rst) gp_latch[g] <= 1'b0;
            else if (bsr_we && bsr_sel == 3'(g)) gp_latch[g] <= bsr_set;
        end
    end

    AST_RESERVED_SEL: assert property (@(posedge clk) disable iff (rst)
        (bsr_we && (bsr_sel == 3'd3 || bsr_sel == 3'd5 || bsr_sel == 3'd7))
        |=> ($stable(inte_in) && $stable(inte_out) && $stable(gp_latch))); // R10
endmodule

// File: rtl/bhp_port.sv
module bhp_port
    import bhp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_a,
    input  logic          rd_a,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          bsr_we,
    input  logic [2:0]    bsr_sel,
    input  logic          bsr_set,
    input  logic [2:0]    gp_dir,
    input  logic [DW-1:0] pa_i,
    output logic [DW-1:0] pa_o,
    output logic          pa_oe,
    input  logic [7:0]    pc_i,
    output logic [7:0]    pc_o,
    output logic [7:0]    pc_oe,
    output logic [7:0]    stat
);
    logic            ibf;
    logic            obf_n;
    logic            out_done;
    logic            inte_in;
    logic            inte_out;
    logic            intr;
    logic [GP_W-1:0] gp_latch;
    logic [GP_W-1:0] gp_view;
    logic [DW-1:0]   out_data;

    bhp_in_ctl #(.DW(DW)) u_in (
        .clk(clk), .rst(rst), .stb_n(pc_i[PIN_STB]), .rd_a(rd_a),
        .pa_i(pa_i), .ibf(ibf), .in_data(rdata)
    );

    bhp_out_ctl #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .ack_n(pc_i[PIN_ACK]), .wr_a(wr_a),
        .wdata(wdata), .out_data(out_data), .obf_n(obf_n), .out_done(out_done)
    );

    bhp_ctl_bits u_bits (
        .clk(clk), .rst(rst), .bsr_we(bsr_we), .bsr_sel(bsr_sel),
        .bsr_set(bsr_set), .inte_in(inte_in), .inte_out(inte_out),
        .gp_latch(gp_latch)
    );

    always_comb begin
        intr  = (ibf & inte_in) | (out_done & inte_out);
        pa_oe = ~pc_i[PIN_ACK];
        pa_o  = out_data;
    end

    for (genvar g = 0; g < GP_W; g++) begin : g_view
        assign gp_view[g] = gp_dir[g] ? gp_latch[g] : pc_i[g];
    end

    always_comb begin
        pc_o           = '0;
        pc_o[PIN_OBF]  = obf_n;
        pc_o[PIN_IBF]  = ibf;
        pc_o[PIN_INTR] = intr;
        pc_o[GP_W-1:0] = gp_latch;
        pc_oe           = '0;
        pc_oe[PIN_OBF]  = 1'b1;
        pc_oe[PIN_IBF]  = 1'b1;
        pc_oe[PIN_INTR] = 1'b1;
        pc_oe[GP_W-1:0] = gp_dir;
        stat = {obf_n, inte_out, ibf, inte_in, intr, gp_view};
    end

    AST_INTR_GATED: assert property (@(posedge clk) disable iff (rst)
        intr |-> (inte_in || inte_out));                  // R8
endmodule

// File: tb/bhp_port_tb.sv
module bhp_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_a = 0, rd_a = 0, bsr_we = 0, bsr_set = 0;
    logic [7:0] wdata = '0, pa_i = '0;
    logic [2:0] bsr_sel = '0, gp_dir = '0;
    logic [7:0] pc_i = 8'b0101_0101;
    logic [7:0] rdata, pa_o, pc_o, pc_oe, stat;
    logic       pa_oe;
    int         n_run = 0, n_fail = 0;
    bit         done = 0;

    always #10 clk = ~clk;

    bhp_port #(.DW(8)) u_dut (
        .clk(clk), .rst(rst), .wr_a(wr_a), .rd_a(rd_a), .wdata(wdata),
        .rdata(rdata), .bsr_we(bsr_we), .bsr_sel(bsr_sel), .bsr_set(bsr_set),
        .gp_dir(gp_dir), .pa_i(pa_i), .pa_o(pa_o), .pa_oe(pa_oe),
        .pc_i(pc_i), .pc_o(pc_o), .pc_oe(pc_oe), .stat(stat)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(logic [7:0] d, logic with_read);
        @(negedge clk);
        pa_i = d; pc_i[4] = 1'b0; rd_a = with_read;
        @(negedge clk);
        pc_i[4] = 1'b1; rd_a = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rd_a = 1'b1;
        @(negedge clk); rd_a = 1'b0;
    endtask

    task automatic host_write(logic [7:0] d);
        @(negedge clk); wr_a = 1'b1; wdata = d;
        @(negedge clk); wr_a = 1'b0;
    endtask

    task automatic bsr(logic [2:0] sel, logic v);
        @(negedge clk); bsr_we = 1'b1; bsr_sel = sel; bsr_set = v;
        @(negedge clk); bsr_we = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 pc_o", pc_o, 8'h80);
        check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
        check("R11 pc_oe", pc_oe, 8'hA8);
        check("R12 stat", stat, 8'h85);
    endtask

    task automatic t_input();
        strobe(8'h3C, 1'b0);
        check("R2 ibf", {7'd0, pc_o[5]}, 8'h01);
        check("R2 rdata", rdata, 8'h3C);
        check("R8 no intr without enable", {7'd0, pc_o[3]}, 8'h00);
        strobe(8'hA5, 1'b0);
        check("R3 overwrite", rdata, 8'hA5);
        check("R3 ibf stays", {7'd0, pc_o[5]}, 8'h01);
        host_read();
        check("R4 read clears", {7'd0, pc_o[5]}, 8'h00);
        strobe(8'h11, 1'b0);
        strobe(8'h5A, 1'b1);
        check("R4 strobe beats read ibf", {7'd0, pc_o[5]}, 8'h01);
        check("R4 strobe beats read data", rdata, 8'h5A);
        host_read();
    endtask

    task automatic t_output();
        host_write(8'h96);
        check("R5 obf low", {7'd0, pc_o[7]}, 8'h00);
        check("R6 no drive", {7'd0, pa_oe}, 8'h00);
        @(negedge clk); pc_i[6] = 1'b0; #1;
        check("R6 oe with ack", {7'd0, pa_oe}, 8'h01);
        check("R6 data", pa_o, 8'h96);
        @(negedge clk);
        check("R7 obf released", {7'd0, pc_o[7]}, 8'h01);
        pc_i[6] = 1'b1; #1;
        check("R6 oe drops", {7'd0, pa_oe}, 8'h00);
        @(negedge clk);
        check("R8 done gated off", {7'd0, pc_o[3]}, 8'h00);
    endtask

    task automatic t_intr();
        bsr(3'd6, 1'b1);
        check("R9 inte_out", {7'd0, stat[6]}, 8'h01);
        check("R8 out intr", {7'd0, pc_o[3]}, 8'h01);
        host_write(8'h42);
        check("R8 write ends intr", {7'd0, pc_o[3]}, 8'h00);
        @(negedge clk); pc_i[6] = 1'b0;
        @(negedge clk);
        check("R8 no intr while ack", {7'd0, pc_o[3]}, 8'h00);
        pc_i[6] = 1'b1;
        @(negedge clk);
        check("R8 intr after release", {7'd0, pc_o[3]}, 8'h01);
        bsr(3'd6, 1'b0);
        check("R8 out term off", {7'd0, pc_o[3]}, 8'h00);
        bsr(3'd4, 1'b1);
        check("R9 inte_in", {7'd0, stat[4]}, 8'h01);
        strobe(8'h77, 1'b0);
        check("R8 in intr", {7'd0, pc_o[3]}, 8'h01);
        host_read();
        check("R8 read ends intr", {7'd0, pc_o[3]}, 8'h00);
    endtask

    task automatic t_bsr();
        logic [7:0] pc_before, st_before;
        pc_before = pc_o; st_before = stat;
        bsr(3'd3, 1'b1); bsr(3'd5, 1'b1); bsr(3'd7, 1'b0);
        check("R10 pc_o unchanged", pc_o, pc_before);
        check("R10 stat unchanged", stat, st_before);
        bsr(3'd1, 1'b1);
        check("R9 gp bit1", pc_o[2:0], 3'b010);
        gp_dir = 3'b010; pc_i[1] = 1'b0; #1;
        check("R11 pc_oe gp", pc_oe, 8'hAA);
        check("R12 gp view", stat[2:0], 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_input();
        t_output();
        t_intr();
        t_bsr();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule